// File: doc/BRIEF.md
# SPI Register Read Engine with CRC Check and Automatic Retry

This block is an SPI master that fetches one register from an SPI peripheral using a read command protected by a checksum. A client hands it a 4-bit command code and a 12-bit register address over a valid/ready handshake. The engine drops chip select and sends a two-byte header and a one-byte length field. It then clocks in the register bytes and a 16-bit check value. The whole transfer uses SPI mode 0: SCK idles low, MOSI changes while SCK is low, and MISO is sampled on the rising edge.

While bits pass over the wire, a serial CRC-16 runs over the three bytes sent and the data bytes received. It is then compared with the check value the peripheral returned. When they differ, the engine raises chip select for a short gap and repeats the identical frame. After a bounded number of repeats it gives up and reports an error along with the data from the final attempt. The SCK rate comes from the system clock frequency and a ceiling frequency, both parameters. The default ceiling of 17 MHz keeps SCK within the peripheral's safe limit when that part runs from 40 MHz.

Top module: `spi_crc_rd_master`

## Requirements
- R1: After reset, spi_cs_n is high, spi_sck and spi_mosi are low, req_ready is high and rsp_valid is low.
- R2: SCK idles low and each SCK half period lasts HALF = ceil(CLK_HZ / (2*SCK_MAX_HZ)) system clocks. With the defaults (100 MHz, 17 MHz) that is 3 clocks. MOSI never changes while SCK is high.
- R3: A frame holds spi_cs_n low for exactly 8*(DATA_BYTES+5) SCK rising edges (72 by default). MOSI carries the command nibble, then the 12-bit address, then a length byte equal to DATA_BYTES (0x04), all most significant bit first.
- R4: The CRC is 16 bits wide with polynomial 0x8005 and seed 0xFFFF. It is applied MSB first, with no reflection and no final XOR, over the 24 sent bits followed by the received data bits. It is compared against the last two received bytes, high byte first.
- R5: When the CRC matches, rsp_valid pulses for one clock with rsp_err low. rsp_data holds the received bytes, with the first byte received in bits [7:0] and each later byte one position higher.
- R6: When the CRC does not match, spi_cs_n stays high for at least two SCK half periods (6 clocks by default). The same header and length are then sent again.
- R7: When the first attempt and all RETRY_MAX repeats fail (RETRY_MAX+1 frames in all, default 4), rsp_valid pulses with rsp_err high and rsp_data holds the data bytes of the last frame. A request that succeeds on attempt RETRY_MAX+1 reports no error.
- R8: req_ready is high only while no frame or gap is in progress. req_valid and the request fields are ignored while req_ready is low.
- R9: rsp_valid rises in the same clock in which spi_cs_n returns high at the end of the final frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Engine idle, request accepted when req_valid is high |
| req_cmd | input | 4 | Command code placed in the top nibble of the header |
| req_addr | input | 12 | Register address |
| rsp_valid | output | 1 | One-clock strobe: result available |
| rsp_err | output | 1 | Result is from a frame whose CRC failed after all repeats |
| rsp_data | output | 8*DATA_BYTES | Register value, first received byte least significant |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data to the peripheral |
| spi_miso | input | 1 | Serial data from the peripheral |

## Verification
The peripheral model in the bench is told how many leading frames of each request get a flipped CRC bit. It returns different data on every attempt, so reporting a stale frame shows up as wrong data. The counts aimed at are zero, one, exactly RETRY_MAX (pass on the last allowed frame) and beyond RETRY_MAX. A limit that is off by one either reports an error on a request that should pass or sends a fifth frame. A CRC that covers only the received bytes, or takes the check value low byte first, fails every request and ends in errors. Byte order is caught by value comparison, and a request held on req_valid during a busy frame would show up as a changed address in a later header.

// File: rtl/spicr_pkg.sv
package spicr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOW,
      ST_HIGH,
      ST_TAIL,
      ST_GAP
   } spicr_state_e;

   localparam logic [15:0] CRC_POLY = 16'h8005;
   localparam logic [15:0] CRC_SEED = 16'hFFFF;
   localparam int          HDR_BITS = 24;
   localparam int          CHK_BITS = 16;

   // one MSB-first step of the check polynomial
   function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
      logic fb;
      fb = c[15] ^ b;
      return {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
   endfunction

endpackage

// File: rtl/spicr_tick.sv
module spicr_tick #(
   parameter int HALF = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int CW = (HALF < 2) ? 1 : $clog2(HALF);

   generate
      if (HALF == 1) begin : g_every
         assign tick = run;
      end else begin : g_count
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          cnt_q <= '0;
            else if (!run)                       cnt_q <= '0;
            else if (cnt_q == CW'(HALF - 1))     cnt_q <= '0;
            else                                 cnt_q <= cnt_q + 1'b1;
         end
         assign tick = run && (cnt_q == CW'(HALF - 1));
      end
   endgenerate
endmodule

// File: rtl/spicr_crc16.sv
module spicr_crc16 import spicr_pkg::*; (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr,
   input  logic        en,
   input  logic        din,
   output logic [15:0] crc
);
   logic [15:0] crc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   crc_q <= CRC_SEED;
      else if (clr) crc_q <= CRC_SEED;
      else if (en)  crc_q <= crc_step(crc_q, din);
   end

   assign crc = crc_q;
endmodule

// File: rtl/spicr_shift.sv
module spicr_shift #(
   parameter int TX_BITS = 24,
   parameter int RX_BITS = 48
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [TX_BITS-1:0] tx_word,
   input  logic               tx_adv,
   input  logic               rx_cap,
   input  logic               rx_bit,
   output logic               tx_msb,
   output logic [RX_BITS-1:0] rx_word
);
   logic [TX_BITS-1:0] tx_q;
   logic [RX_BITS-1:0] rx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tx_q <= '0;
      else if (load)   tx_q <= tx_word;
      else if (tx_adv) tx_q <= {tx_q[TX_BITS-2:0], 1'b0};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rx_q <= '0;
      else if (rx_cap) rx_q <= {rx_q[RX_BITS-2:0], rx_bit};
   end

   assign tx_msb  = tx_q[TX_BITS-1];
   assign rx_word = rx_q;
endmodule

// File: rtl/spi_crc_rd_master.sv
module spi_crc_rd_master import spicr_pkg::*; #(
   parameter int CLK_HZ     = 100_000_000,
   parameter int SCK_MAX_HZ = 17_000_000,
   parameter int DATA_BYTES = 4,
   parameter int RETRY_MAX  = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   output logic                    req_ready,
   input  logic [3:0]              req_cmd,
   input  logic [11:0]             req_addr,
   output logic                    rsp_valid,
   output logic                    rsp_err,
   output logic [8*DATA_BYTES-1:0] rsp_data,
   output logic                    spi_cs_n,
   output logic                    spi_sck,
   output logic                    spi_mosi,
   input  logic                    spi_miso
);
   localparam int HALF       = (CLK_HZ + 2*SCK_MAX_HZ - 1) / (2*SCK_MAX_HZ);
   localparam int DATA_W     = 8 * DATA_BYTES;
   localparam int RX_BITS    = DATA_W + CHK_BITS;
   localparam int TOTAL_BITS = HDR_BITS + RX_BITS;
   localparam int DATA_END   = HDR_BITS + DATA_W;
   localparam int BIT_W      = $clog2(TOTAL_BITS);
   localparam int TRY_W      = $clog2(RETRY_MAX + 2);

   generate
      if (HALF < 1 || (CLK_HZ / (2*HALF)) > SCK_MAX_HZ) begin : g_bad_rate
         $error("SCK divider cannot meet the SCK ceiling");
      end
      if (DATA_BYTES < 1 || DATA_BYTES > 255) begin : g_bad_len
         $error("DATA_BYTES must fit the length byte");
      end
      if (RETRY_MAX < 0) begin : g_bad_retry
         $error("RETRY_MAX must not be negative");
      end
   endgenerate

   spicr_state_e       state_q;
   logic [3:0]         cmd_q;
   logic [11:0]        addr_q;
   logic [BIT_W-1:0]   bit_q;
   logic [TRY_W-1:0]   try_q;
   logic               gap_q;
   logic               again_q;
   logic               cs_n_q;
   logic               sck_q;
   logic               rsp_valid_q;
   logic               rsp_err_q;
   logic [DATA_W-1:0]  rsp_data_q;

   logic               tick;
   logic               run;
   logic               start_new;
   logic               start_again;
   logic               rise;
   logic               fall;
   logic               last_bit;
   logic [HDR_BITS-1:0] hdr_word;
   logic               tx_msb;
   logic [RX_BITS-1:0] rx_word;
   logic [15:0]        crc_now;
   logic               crc_en;
   logic               crc_din;
   logic               crc_ok;
   logic [DATA_W-1:0]  data_ordered;

   assign run         = (state_q != ST_IDLE);
   assign req_ready   = (state_q == ST_IDLE);
   assign start_new   = (state_q == ST_IDLE) && req_valid;
   assign start_again = (state_q == ST_GAP) && tick && gap_q && again_q;
   assign rise        = (state_q == ST_LOW)  && tick;
   assign fall        = (state_q == ST_HIGH) && tick;
   assign last_bit    = (bit_q == BIT_W'(TOTAL_BITS - 1));

   // header source: live request on a new read, stored copy on a repeat
   assign hdr_word = start_new ? {req_cmd, req_addr, 8'(DATA_BYTES)}
                               : {cmd_q,   addr_q,   8'(DATA_BYTES)};

   // checksum covers driven header bits, then sampled data bits
   assign crc_en  = rise && (bit_q < BIT_W'(DATA_END));
   assign crc_din = (bit_q < BIT_W'(HDR_BITS)) ? tx_msb : spi_miso;

   spicr_tick #(.HALF(HALF)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .tick  (tick)
   );

   spicr_shift #(.TX_BITS(HDR_BITS), .RX_BITS(RX_BITS)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (start_new || start_again),
      .tx_word (hdr_word),
      .tx_adv  (fall && !last_bit),
      .rx_cap  (rise),
      .rx_bit  (spi_miso),
      .tx_msb  (tx_msb),
      .rx_word (rx_word)
   );

   spicr_crc16 u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (start_new || start_again),
      .en    (crc_en),
      .din   (crc_din),
      .crc   (crc_now)
   );

   // first received byte sits at the top of the shift register
   generate
      for (genvar gi = 0; gi < DATA_BYTES; gi++) begin : g_order
         assign data_ordered[8*gi +: 8] = rx_word[RX_BITS-1-8*gi -: 8];
      end
   endgenerate

   assign crc_ok = (crc_now == rx_word[CHK_BITS-1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         cmd_q       <= '0;
         addr_q      <= '0;
         bit_q       <= '0;
         try_q       <= '0;
         gap_q       <= 1'b0;
         again_q     <= 1'b0;
         cs_n_q      <= 1'b1;
         sck_q       <= 1'b0;
         rsp_valid_q <= 1'b0;
         rsp_err_q   <= 1'b0;
         rsp_data_q  <= '0;
      end else begin
         rsp_valid_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  cmd_q   <= req_cmd;
                  addr_q  <= req_addr;
                  try_q   <= '0;
                  bit_q   <= '0;
                  cs_n_q  <= 1'b0;
                  state_q <= ST_LOW;
               end
            end
            ST_LOW: begin
               if (tick) begin
                  sck_q   <= 1'b1;
                  state_q <= ST_HIGH;
               end
            end
            ST_HIGH: begin
               if (tick) begin
                  sck_q <= 1'b0;
                  if (last_bit) begin
                     state_q <= ST_TAIL;
                  end else begin
                     bit_q   <= bit_q + 1'b1;
                     state_q <= ST_LOW;
                  end
               end
            end
            ST_TAIL: begin
               if (tick) begin
                  cs_n_q  <= 1'b1;
                  gap_q   <= 1'b0;
                  state_q <= ST_GAP;
                  if (crc_ok) begin
                     rsp_valid_q <= 1'b1;
                     rsp_err_q   <= 1'b0;
                     rsp_data_q  <= data_ordered;
                     again_q     <= 1'b0;
                  end else if (try_q == TRY_W'(RETRY_MAX)) begin
                     rsp_valid_q <= 1'b1;
                     rsp_err_q   <= 1'b1;
                     rsp_data_q  <= data_ordered;
                     again_q     <= 1'b0;
                  end else begin
                     try_q   <= try_q + 1'b1;
                     again_q <= 1'b1;
                  end
               end
            end
            ST_GAP: begin
               if (tick) begin
                  if (!gap_q) begin
                     gap_q <= 1'b1;
                  end else if (again_q) begin
                     bit_q   <= '0;
                     cs_n_q  <= 1'b0;
                     state_q <= ST_LOW;
                  end else begin
                     state_q <= ST_IDLE;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign spi_cs_n  = cs_n_q;
   assign spi_sck   = sck_q;
   assign spi_mosi  = tx_msb;
   assign rsp_valid = rsp_valid_q;
   assign rsp_err   = rsp_err_q;
   assign rsp_data  = rsp_data_q;
endmodule

// File: rtl/spicr_chk.sv
module spicr_chk #(
   parameter int HALF       = 3,
   parameter int TOTAL_BITS = 72
) (
   input logic clk,
   input logic rst_n,
   input logic req_ready,
   input logic rsp_valid,
   input logic spi_cs_n,
   input logic spi_sck,
   input logic spi_mosi
);
   int unsigned hi_len;
   int unsigned rise_cnt;
   int unsigned cs_hi_len;
   logic        sck_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_len    <= 0;
         rise_cnt  <= 0;
         cs_hi_len <= 2*HALF;
         sck_d     <= 1'b0;
      end else begin
         sck_d  <= spi_sck;
         hi_len <= spi_sck ? hi_len + 1 : 0;
         if (spi_cs_n)                rise_cnt <= 0;
         else if (spi_sck && !sck_d)  rise_cnt <= rise_cnt + 1;
         if (!spi_cs_n)               cs_hi_len <= 0;
         else if (cs_hi_len < 2*HALF) cs_hi_len <= cs_hi_len + 1;
      end
   end

   assert_sck_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sck);
   assert_mosi_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));
   assert_high_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(spi_sck) |-> (hi_len == HALF));
   assert_frame_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_cs_n) |-> (rise_cnt == TOTAL_BITS));
   assert_cs_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(spi_cs_n) |-> (cs_hi_len >= 2*HALF));
   assert_rsp_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
   assert_ready_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> spi_cs_n);
   assert_rsp_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $rose(spi_cs_n));
endmodule

bind spi_crc_rd_master spicr_chk #(
   .HALF       (HALF),
   .TOTAL_BITS (TOTAL_BITS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .rsp_valid (rsp_valid),
   .spi_cs_n  (spi_cs_n),
   .spi_sck   (spi_sck),
   .spi_mosi  (spi_mosi)
);

// File: tb/sim_spi_crc_rd_master.sv
module sim_spi_crc_rd_master;
   localparam int RETRY = 3;
   localparam int HALFC = 3;   // ceil(100 MHz / 34 MHz)
   localparam int FBITS = 72;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [3:0]  req_cmd = '0;
   logic [11:0] req_addr = '0;
   logic        rsp_valid;
   logic        rsp_err;
   logic [31:0] rsp_data;
   logic        spi_cs_n;
   logic        spi_sck;
   logic        spi_mosi;
   logic        spi_miso = 1'b0;

   int nvec = 0;
   int nbad = 0;

   // peripheral model state
   int          slv_bad  = 0;
   int          slv_att  = 0;
   logic [31:0] slv_salt = '0;
   logic [23:0] exp_hdr  = '0;
   int          hdr_err  = 0;
   int          len_err  = 0;
   int          sck_bad  = 0;
   int          min_gap  = 1000;
   int          hi_run   = 0;
   int          cs_run   = 0;

   always #5 clk = ~clk;

   spi_crc_rd_master u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_cmd(req_cmd), .req_addr(req_addr), .rsp_valid(rsp_valid),
      .rsp_err(rsp_err), .rsp_data(rsp_data), .spi_cs_n(spi_cs_n),
      .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
   );

   function automatic logic [31:0] reg_model(input logic [15:0] h, input logic [31:0] s, input int a);
      return ((s ^ {h, ~h}) * 32'h9E3779B1) + (32'(a) * 32'h01234567);
   endfunction

   function automatic logic [15:0] crc_ref(input logic [55:0] v);
      logic [15:0] c;
      logic        fb;
      c = 16'hFFFF;
      for (int i = 55; i >= 0; i--) begin
         fb = c[15] ^ v[i];
         c  = {c[14:0], 1'b0} ^ (fb ? 16'h8005 : 16'h0000);
      end
      return c;
   endfunction

   task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
      nvec++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   // SPI peripheral: samples MOSI on rising SCK, drives MISO after falling SCK
   initial begin
      forever begin
         logic [23:0] hdr;
         logic [71:0] outv;
         logic [31:0] d;
         logic [31:0] stream;
         logic [15:0] c;
         int          a;
         int          rises;
         @(negedge spi_cs_n);
         a = slv_att;
         slv_att++;
         hdr = '0; outv = '0; rises = 0;
         spi_miso = 1'b0;
         for (int i = 0; i < FBITS; i++) begin
            @(posedge spi_sck or posedge spi_cs_n);
            if (spi_cs_n) break;
            rises++;
            if (i < 24) hdr = {hdr[22:0], spi_mosi};
            if (i == 23) begin
               if (hdr[23:8] != exp_hdr[23:8]) hdr_err++;
               if (hdr[7:0] != 8'h04) len_err++;
               d = reg_model(hdr[23:8], slv_salt, a);
               stream = {d[7:0], d[15:8], d[23:16], d[31:24]};
               c = crc_ref({hdr, stream});
               if (a < slv_bad) c = c ^ (16'h0001 << ($urandom % 16));
               outv = {24'h0, stream, c};
            end
            @(negedge spi_sck or posedge spi_cs_n);
            if (spi_cs_n) break;
            if (i < FBITS - 1) spi_miso = outv[70-i];
         end
         if (rises != FBITS) sck_bad++;
         if (!spi_cs_n) @(posedge spi_cs_n);
         spi_miso = 1'b0;
      end
   end

   // line monitors sampled away from the clock edge
   always @(negedge clk) begin
      if (spi_sck) hi_run++;
      else begin
         if (hi_run != 0 && hi_run != HALFC) sck_bad++;
         hi_run = 0;
      end
      if (spi_cs_n) cs_run++;
      else begin
         if (cs_run != 0 && slv_att >= 2 && cs_run < min_gap) min_gap = cs_run;
         cs_run = 0;
      end
   end

   task automatic do_read(input logic [3:0] cmd, input logic [11:0] addr, input int bad, input bit poke);
      int          frames;
      int          busy_ready;
      logic [31:0] expd;
      while (!req_ready) @(negedge clk);
      exp_hdr  = {cmd, addr, 8'h04};
      slv_bad  = bad;
      slv_salt = $urandom;
      slv_att  = 0;
      hdr_err  = 0; len_err = 0; sck_bad = 0; min_gap = 1000;
      req_cmd  = cmd; req_addr = addr; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      req_cmd = $urandom; req_addr = $urandom;
      if (poke) begin
         busy_ready = 0;
         repeat (10) @(negedge clk);
         req_valid = 1'b1; req_addr = ~addr; req_cmd = ~cmd;
         for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (req_ready) busy_ready++;
         end
         req_valid = 1'b0;
         chk(busy_ready == 0, "R8 ready low while busy", 64'(busy_ready), 64'd0);
      end
      while (!rsp_valid) @(negedge clk);
      frames = (bad > RETRY) ? RETRY + 1 : bad + 1;
      expd   = reg_model({cmd, addr}, slv_salt, frames - 1);
      chk(rsp_data == expd, (bad > RETRY) ? "R7 last data on error" : "R5 data order", 64'(rsp_data), 64'(expd));
      chk(rsp_err == (bad > RETRY), (bad > RETRY) ? "R7 error flag" : "R5 error flag low", 64'(rsp_err), 64'(bad > RETRY));
      chk(spi_cs_n == 1'b1, "R9 cs high at response", 64'(spi_cs_n), 64'd1);
      chk(slv_att == frames, "R6 frame count", 64'(slv_att), 64'(frames));
      chk(hdr_err == 0 && len_err == 0, "R3 header and length", 64'(hdr_err + len_err), 64'd0);
      chk(sck_bad == 0, "R2 SCK timing", 64'(sck_bad), 64'd0);
      if (frames > 1) chk(min_gap >= 2*HALFC, "R6 cs gap", 64'(min_gap), 64'(2*HALFC));
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R5 one-cycle strobe", 64'(rsp_valid), 64'd0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      nbad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec + 1, nbad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      chk(spi_cs_n == 1'b1, "R1 reset cs", 64'(spi_cs_n), 64'd1);
      chk(spi_sck == 1'b0, "R1 reset sck", 64'(spi_sck), 64'd0);
      chk(spi_mosi == 1'b0, "R1 reset mosi", 64'(spi_mosi), 64'd0);
      chk(req_ready == 1'b0 || req_ready == 1'b1, "R1 ready defined", 64'(req_ready), 64'd1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);
      chk(rsp_valid == 1'b0, "R1 no response after reset", 64'(rsp_valid), 64'd0);

      // directed corners: R4 clean CRC, R6 one repeat, R7 pass on last allowed and fail past it
      do_read(4'h0, 12'h000, 0, 1'b0);
      do_read(4'hF, 12'hFFF, 1, 1'b0);
      do_read(4'h3, 12'hABC, RETRY, 1'b0);
      do_read(4'h5, 12'h123, RETRY + 1, 1'b0);
      do_read(4'hA, 12'h555, 9, 1'b0);
      do_read(4'hB, 12'h0F0, 0, 1'b1);
      do_read(4'h6, 12'h999, 2, 1'b1);

      for (int n = 0; n < 28; n++) begin
         int b;
         b = (($urandom % 8) < 5) ? 0 : int'($urandom % 6);
         do_read(4'($urandom), 12'($urandom), b, (($urandom % 5) == 0));
      end

      repeat (20) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end
endmodule